// File: doc/BRIEF.md
# LCD Controller Register File

This block is the software-visible control and status store of a framebuffer LCD controller. A processor reads and writes it over a plain 32-bit word bus: an address, a write strobe, write data and combinational read data. It holds one control word, three timing words, a status word and a subpanel word. It presents their decoded fields to the pixel fetch and panel timing logic as plain outputs: enable, mono and TFT flags, palette-load mode, interrupt enables, active width and height, timing fields and subpanel settings.

The fetch logic reports events with single-cycle pulses: frame finished, palette loaded and sync lost. Each pulse sets a sticky status flag. The frame and palette flags are gated by their interrupt enables and combined into one level-sensitive interrupt line. Software cannot clear the flags through the bus. They are cleared by a dedicated clear pulse, or when the controller is switched on again. Whenever the enable bit changes value, the block emits a one-cycle notification to the fetch logic.

Top module: `lcdc_regs`

## Requirements
- R1: After reset, every stored field is zero, width and height read as 1, all status flags, `irq` and `en_changed` are 0, and the control word reads 0xFE000C34.
- R2: Control (offset 0x00) write: bit 0 is enable, bit 1 is mono, bits 4:3 are interrupt enables, bit 7 is TFT and bits 21:20 are palette-load mode. The remaining bits are kept under mask 0x01CFF300. A read returns these fields in place, with TFT also at bit 23, ORed with 0xFE000C34.
- R3: Timing0 (offset 0x04) write: `width` becomes bits 9:0 plus one and `h_timing` takes bits 31:10. A read returns `h_timing<<10 | (width-1) | 0xF`.
- R4: Timing1 (offset 0x08) handles `height` and `v_timing` the same way, but a read has no 0xF fill. Timing2 (offset 0x0C) stores all 32 bits and reads back ORed with 0xFC000000.
- R5: Subpanel (offset 0x14) write stores only the bits under mask 0xA1FFFFFF. A read returns the stored value.
- R6: A `frame_done_set`, `palette_done_set` or `sync_error_set` pulse sets its flag from the next cycle on. A status read (offset 0x10) shows palette-done at bit 6, sync-error at bit 2 and frame-done at bit 0, with all other bits zero. Writes to the status offset change nothing.
- R7: All three flags clear on a `flag_clear` pulse, or on a control write that takes enable from 0 to 1. A set pulse in the same cycle as a clear wins for its own flag.
- R8: `irq` is high exactly when (frame-done and enable bit 0) or (palette-done and enable bit 1). Sync-error never drives it.
- R9: A control write whose bit 0 differs from the current enable raises `en_changed` for exactly the following cycle.
- R10: Offsets 0x18 to 0xFC read zero and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the word |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| frame_done_set | input | 1 | Pulse: frame fetched |
| palette_done_set | input | 1 | Pulse: palette loaded |
| sync_error_set | input | 1 | Pulse: fetch lost sync |
| flag_clear | input | 1 | Pulse: clear all status flags |
| lcd_en | output | 1 | Controller enable |
| mono | output | 1 | Monochrome panel |
| tft | output | 1 | Active-matrix panel |
| irq_en | output | 2 | Interrupt enables (bit 0 frame, bit 1 palette) |
| load_mode | output | 2 | Palette-load mode |
| width | output | 11 | Active pixels per line |
| height | output | 11 | Active lines |
| h_timing | output | 22 | Horizontal timing field |
| v_timing | output | 22 | Vertical timing field |
| timing2 | output | 32 | Third timing word |
| subpanel | output | 32 | Masked subpanel word |
| irq | output | 1 | Level interrupt |
| en_changed | output | 1 | One-cycle enable change notice |

## Verification
Two functions can meet in one cycle: the setting of a status flag by a fetch pulse, and the clearing of that flag. The clear may come from the clear pulse or from a control write that re-enables the controller. The bench drives these together on purpose, both in directed cases and through random stimulus that can stack all of them in a single cycle. It then judges the outcome from the status word and `irq` in the next cycle: a flag whose set pulse was present must stay set, and every other flag must be cleared.

// File: rtl/lcdc_regs.sv
module lcdc_regs #(
  parameter int ADDR_W = 8,
  parameter int SIZE_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                frame_done_set,
  input  logic                palette_done_set,
  input  logic                sync_error_set,
  input  logic                flag_clear,
  output logic                lcd_en,
  output logic                mono,
  output logic                tft,
  output logic [1:0]          irq_en,
  output logic [1:0]          load_mode,
  output logic [SIZE_W:0]     width,
  output logic [SIZE_W:0]     height,
  output logic [31-SIZE_W:0]  h_timing,
  output logic [31-SIZE_W:0]  v_timing,
  output logic [31:0]         timing2,
  output logic [31:0]         subpanel,
  output logic                irq,
  output logic                en_changed
);
  localparam int TIM_W = 32 - SIZE_W;
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_TIM0 = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_TIM1 = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_TIM2 = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFF_SUBP = ADDR_W'(8'h14);
  localparam logic [31:0] CTRL_KEEP = 32'h01CF_F300;
  localparam logic [31:0] CTRL_ONES = 32'hFE00_0C34;
  localparam logic [31:0] SUBP_KEEP = 32'hA1FF_FFFF;

  logic [31:0]       ctrl_rest;
  logic [SIZE_W-1:0] w_m1, h_m1;
  logic              fd_q, pd_q, se_q;

  wire wr_ctrl  = bus_we && bus_addr == OFF_CTRL;
  wire en_rise  = wr_ctrl && bus_wdata[0] && !lcd_en;
  wire clr_all  = flag_clear || en_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcd_en <= 1'b0; mono <= 1'b0; tft <= 1'b0;
      irq_en <= '0; load_mode <= '0; ctrl_rest <= '0;
      h_timing <= '0; w_m1 <= '0; v_timing <= '0; h_m1 <= '0;
      timing2 <= '0; subpanel <= '0; en_changed <= 1'b0;
    end else begin
      en_changed <= wr_ctrl && (bus_wdata[0] != lcd_en);
      if (bus_we) begin
        case (bus_addr)
          OFF_CTRL: begin
            lcd_en    <= bus_wdata[0];
            mono      <= bus_wdata[1];
            irq_en    <= bus_wdata[4:3];
            tft       <= bus_wdata[7];
            load_mode <= bus_wdata[21:20];
            ctrl_rest <= bus_wdata & CTRL_KEEP;
          end
          OFF_TIM0: begin
            h_timing <= bus_wdata[31:SIZE_W];
            w_m1     <= bus_wdata[SIZE_W-1:0];
          end
          OFF_TIM1: begin
            v_timing <= bus_wdata[31:SIZE_W];
            h_m1     <= bus_wdata[SIZE_W-1:0];
          end
          OFF_TIM2: timing2  <= bus_wdata;
          OFF_SUBP: subpanel <= bus_wdata & SUBP_KEEP;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fd_q <= 1'b0; pd_q <= 1'b0; se_q <= 1'b0;
    end else begin
      fd_q <= frame_done_set   || (fd_q && !clr_all);
      pd_q <= palette_done_set || (pd_q && !clr_all);
      se_q <= sync_error_set   || (se_q && !clr_all);
    end
  end

  assign width  = {1'b0, w_m1} + 1'b1;
  assign height = {1'b0, h_m1} + 1'b1;
  assign irq    = (fd_q && irq_en[0]) || (pd_q && irq_en[1]);

  always_comb begin
    case (bus_addr)
      OFF_CTRL: bus_rdata = ctrl_rest | CTRL_ONES | {8'b0, tft, 1'b0, load_mode, 12'b0,
                                                     tft, 2'b0, irq_en, 1'b0, mono, lcd_en};
      OFF_TIM0: bus_rdata = {h_timing, w_m1} | 32'hF;
      OFF_TIM1: bus_rdata = {v_timing, h_m1};
      OFF_TIM2: bus_rdata = timing2 | 32'hFC00_0000;
      OFF_STAT: bus_rdata = {25'b0, pd_q, 3'b0, se_q, 1'b0, fd_q};
      OFF_SUBP: bus_rdata = subpanel;
      default:  bus_rdata = '0;
    endcase
  end

  logic unused_tim;
  assign unused_tim = ^TIM_W;
endmodule

// File: rtl/lcdc_regs_chk.sv
module lcdc_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int SIZE_W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_we,
  input logic [31:0]        bus_wdata,
  input logic               frame_done_set,
  input logic               palette_done_set,
  input logic               flag_clear,
  input logic               lcd_en,
  input logic [1:0]         irq_en,
  input logic [SIZE_W:0]    width,
  input logic [SIZE_W:0]    height,
  input logic               irq,
  input logic               en_changed
);
  assert_width_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(8'h04)) |=>
      width == ({1'b0, $past(bus_wdata[SIZE_W-1:0])} + 1'b1));

  assert_size_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(width) && $stable(height)));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done_set && irq_en[0] && !bus_we) |=> irq);

  assert_clear_drops_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clear && !frame_done_set && !palette_done_set) |=> !irq);

  assert_change_notice_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(8'h00) && bus_wdata[0] != lcd_en) |=>
      (en_changed && lcd_en != $past(lcd_en)));
endmodule

bind lcdc_regs lcdc_regs_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .frame_done_set(frame_done_set),
  .palette_done_set(palette_done_set), .flag_clear(flag_clear),
  .lcd_en(lcd_en), .irq_en(irq_en), .width(width), .height(height),
  .irq(irq), .en_changed(en_changed));

// File: tb/lcdc_regs_tb_top.sv
`timescale 1ns/1ps
module lcdc_regs_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic fds = 0, pds = 0, ses = 0, fclr = 0;
  logic lcd_en, mono, tft, irq, en_changed;
  logic [1:0] irq_en, load_mode;
  logic [10:0] width, height;
  logic [21:0] h_timing, v_timing;
  logic [31:0] timing2, subpanel;

  always #5 clk = ~clk;

  lcdc_regs dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_done_set(fds),
    .palette_done_set(pds), .sync_error_set(ses), .flag_clear(fclr),
    .lcd_en(lcd_en), .mono(mono), .tft(tft), .irq_en(irq_en), .load_mode(load_mode),
    .width(width), .height(height), .h_timing(h_timing), .v_timing(v_timing),
    .timing2(timing2), .subpanel(subpanel), .irq(irq), .en_changed(en_changed));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model, stored as the requirements describe it
  logic [31:0] m_ctrl, m_t0, m_t1, m_t2, m_sub;
  logic m_fd, m_pd, m_se, m_chg;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      8'h00: return (m_ctrl & 32'h01CF_F300) | 32'hFE00_0C34 | (m_ctrl & 32'h0030_009B)
                    | ({31'b0, m_ctrl[7]} << 23);
      8'h04: return m_t0 | 32'hF;
      8'h08: return m_t1;
      8'h0C: return m_t2 | 32'hFC00_0000;
      8'h10: return {25'b0, m_pd, 3'b0, m_se, 1'b0, m_fd};
      8'h14: return m_sub;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_ctrl = 0; m_t0 = 0; m_t1 = 0; m_t2 = 0; m_sub = 0;
    m_fd = 0; m_pd = 0; m_se = 0; m_chg = 0;
  endtask

  task automatic step(logic we, logic [7:0] a, logic [31:0] d,
                      logic f, logic p, logic s, logic c);
    logic rise, clr;
    bus_we = we; bus_addr = a; bus_wdata = d; fds = f; pds = p; ses = s; fclr = c;
    @(posedge clk);
    rise  = we && a == 8'h00 && d[0] && !m_ctrl[0];
    clr   = c || rise;
    m_chg = we && a == 8'h00 && d[0] != m_ctrl[0];
    m_fd = f | (m_fd & ~clr);
    m_pd = p | (m_pd & ~clr);
    m_se = s | (m_se & ~clr);
    if (we) case (a)
      8'h00: m_ctrl = d & (32'h01CF_F300 | 32'h0030_009B);
      8'h04: m_t0 = d;
      8'h08: m_t1 = d;
      8'h0C: m_t2 = d;
      8'h14: m_sub = d & 32'hA1FF_FFFF;
      default: ;
    endcase
    @(negedge clk);
    bus_we = 0; fds = 0; pds = 0; ses = 0; fclr = 0;
  endtask

  task automatic check_outputs();
    check("R2 fields", {lcd_en, mono, tft, irq_en, load_mode},
          {m_ctrl[0], m_ctrl[1], m_ctrl[7], m_ctrl[4:3], m_ctrl[21:20]});
    check("R3 width", {h_timing, width}, {m_t0[31:10], 11'(m_t0[9:0]) + 11'd1});
    check("R4 height", {v_timing, height}, {m_t1[31:10], 11'(m_t1[9:0]) + 11'd1});
    check("R4 timing2 R5 subpanel", timing2 ^ subpanel, m_t2 ^ m_sub);
    check("R8 irq", irq, (m_fd & m_ctrl[3]) | (m_pd & m_ctrl[4]));
    check("R9 en_changed", en_changed, m_chg);
  endtask

  task automatic read_chk(logic [7:0] a, string tag);
    bus_addr = a; #1;
    check(tag, bus_rdata, exp_read(a));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_outputs();
    read_chk(8'h00, "R1 control reset");
    read_chk(8'h04, "R1 timing0 reset");
    read_chk(8'h10, "R1 status reset");
    check("R1 width", width, 11'd1);

    // R3 max width, R4
    step(1, 8'h04, 32'hFFFF_FFFF, 0, 0, 0, 0); check_outputs();
    check("R3 width max", width, 11'd1024);
    read_chk(8'h04, "R3 timing0 read");
    step(1, 8'h08, 32'h1234_5601, 0, 0, 0, 0); read_chk(8'h08, "R4 timing1 read");
    step(1, 8'h0C, 32'h0000_00AA, 0, 0, 0, 0); read_chk(8'h0C, "R4 timing2 read");
    step(1, 8'h14, 32'hFFFF_FFFF, 0, 0, 0, 0); read_chk(8'h14, "R5 subpanel mask");
    // R2 control with all ones
    step(1, 8'h00, 32'hFFFF_FFFE, 0, 0, 0, 0); read_chk(8'h00, "R2 control read");
    check_outputs();
    // R6 set flags, status write ignored
    step(0, 8'h00, 0, 1, 1, 1, 0); read_chk(8'h10, "R6 status bits");
    check("R8 irq both", irq, 1'b1);
    step(1, 8'h10, 32'h0, 0, 0, 0, 0); read_chk(8'h10, "R6 status write ignored");
    // R7 clear with set in same cycle
    step(0, 8'h00, 0, 1, 0, 0, 1); read_chk(8'h10, "R7 set wins over clear");
    // R7 enable rise clears, R9 notice
    step(0, 8'h00, 0, 0, 1, 1, 0);
    step(1, 8'h00, 32'h0000_0019, 0, 0, 0, 0); read_chk(8'h10, "R7 enable rise clears");
    check("R9 pulse", en_changed, 1'b1);
    step(0, 8'h00, 0, 0, 0, 0, 0); check("R9 single cycle", en_changed, 1'b0);
    // R10 unmapped
    step(1, 8'h18, 32'hFFFF_FFFF, 0, 0, 0, 0); check_outputs();
    read_chk(8'h18, "R10 unmapped read");
    read_chk(8'h1C, "R10 unmapped read 1C");

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      a = 8'(($urandom % 8) * 4);
      step(($urandom % 2) == 0, a, $urandom,
           ($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 5) == 0,
           ($urandom % 6) == 0);
      check_outputs();
      read_chk(8'(($urandom % 8) * 4), "R2 R6 R10 random read");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule